// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory, meant for simulation and FPGA emulation of a system that boots from such a part. The pins are sampled on a system clock. Two active-low strobes select the part and gate its output. A flag stands for the raised programming supply, and a second flag stands for the high voltage applied to address bit 9. The bidirectional data bus is split into an input byte, an output byte and an output-drive enable.

From these inputs the block decodes one operating mode every cycle. The modes are read, output disable, standby, program, verify, program inhibit and identification. Any combination that matches none of them raises a mode-error flag. A program pulse is the chip select held low while the supply flag is high and the output strobe is high. The pulse commits one byte when the chip select rises again. Programming can only clear bits, so the stored byte becomes the old byte ANDed with the applied byte. Reset plays the part of an erase and returns every byte to all ones.

To keep the register array small, only the low `STORE_AW` address bits select storage. Higher addresses mirror the stored window.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every location reads 0xFF.
- R2: A committed program operation stores (old byte AND applied byte), so a bit that reads 0 never returns to 1.
- R3: With both strobes low, the supply flag low and the identification flag low, `dout_en` is 1 and `dout` shows the byte at `addr`.
- R4: With `ce_n` high and the supply flag low (standby), `dout_en` is 0 and `dout` is 0x00 for either level of `oe_n`.
- R5: With `ce_n` low, `oe_n` high and the supply flag low (output disable), `dout_en` is 0 and `dout` is 0x00.
- R6: A write happens only on the first clock at which `ce_n` is seen high after one or more program-pulse cycles (`ce_n` low, `oe_n` high, `vpp_hi` high), and only if `vpp_hi` is still high at that clock. The write uses the `addr` and `din` present at that clock and happens once per pulse.
- R7: With `ce_n`, `oe_n` and `vpp_hi` all high (program inhibit), no location changes and `dout_en` is 0.
- R8: With `ce_n` high, `oe_n` low and `vpp_hi` high (verify), `dout_en` is 1 and `dout` shows the byte at `addr`.
- R9: With both strobes low, `vpp_hi` low and `id_hv` high, `dout` is 0x20 when `addr[0]` is 0 and 0x8D when `addr[0]` is 1, with `dout_en` high.
- R10: With both strobes low and `vpp_hi` high, `mode_err` is 1 and `dout_en` is 0. If this happens during a program pulse, the pulse is abandoned and writes nothing. `mode_err` is 0 in every other mode.
- R11: Addresses that agree in their low `STORE_AW` bits (10 by default) refer to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; returns every byte to all ones |
| ce_n | input | 1 | Active-low chip select / program strobe |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | High voltage present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data bus as driven into the part |
| dout | output | DATA_W | Data bus as driven by the part (0 when not driving) |
| dout_en | output | 1 | The part drives the data bus |
| mode_err | output | 1 | Pin combination matches no defined mode |

## Verification
The hardest case to reach is the end of a program pulse. At that clock the chip select has risen, but the supply flag, the address and the data may all have changed in the same cycle. An output-strobe glitch inside the pulse must also cancel the pulse. The stimulus builds pulses of several lengths. It then ends each one with a different combination: a new address and new data at the rising edge, the supply dropping at the same edge, and an illegal cycle inserted before the edge. A bench model that knows only the mode rules predicts which location changes, and every later read is compared with that model on each clock.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUTDIS,
    M_READ,
    M_IDENT,
    M_PROGRAM,
    M_VERIFY,
    M_INHIBIT,
    M_ILLEGAL
  } otp_mode_e;

  // programming can only clear bits
  function automatic logic [7:0] burn_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // identification byte chosen by the lowest address bit
  function automatic logic [7:0] ident_pick(input logic sel, input logic [7:0] code0,
                                            input logic [7:0] code1);
    return sel ? code1 : code0;
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  input  logic      id_hv,
  output otp_mode_e mode,
  output logic      mode_err
);

  always_comb begin
    if (!vpp_hi) begin
      if (ce_n)       mode = M_STANDBY;
      else if (oe_n)  mode = M_OUTDIS;
      else if (id_hv) mode = M_IDENT;
      else            mode = M_READ;
    end else begin
      if (ce_n && oe_n)  mode = M_INHIBIT;
      else if (ce_n)     mode = M_VERIFY;
      else if (oe_n)     mode = M_PROGRAM;
      else               mode = M_ILLEGAL;
    end
  end

  assign mode_err = (mode == M_ILLEGAL);

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int STORE_AW = 10,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  otp_mode_e           mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   din,
  output logic                wr_en,
  output logic [STORE_AW-1:0] wr_addr,
  output logic [DATA_W-1:0]   wr_data
);

  logic pulse_q;
  logic pulse_now;
  logic pulse_closing;

  assign pulse_now = (mode == M_PROGRAM);
  // select rose while the supply is still raised
  assign pulse_closing = pulse_q && (mode == M_INHIBIT || mode == M_VERIFY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_now;
  end

  assign wr_en   = pulse_closing;
  assign wr_addr = addr[STORE_AW-1:0];
  assign wr_data = din;

  assert_write_ends_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(mode) == M_PROGRAM));

  assert_inhibit_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_INHIBIT && $past(mode) == M_INHIBIT) |-> !wr_en);

  assert_illegal_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_ILLEGAL) |-> !wr_en);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int STORE_AW = 10,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [STORE_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [STORE_AW-1:0] rd_addr,
  output logic [DATA_W-1:0]   rd_data
);

  localparam int DEPTH = 1 << STORE_AW;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[wr_addr] <= burn_merge(cells[wr_addr], wr_data);
    end
  end

  assign rd_data = cells[rd_addr];

  // a bit seen at 0 never reads 1 again at the same location
  assert_no_bit_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_addr) |-> ((~$past(rd_data) & rd_data) == '0));

endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux
  import otp_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'h8D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  otp_mode_e         mode,
  input  logic              sel0,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  always_comb begin
    dout    = '0;
    dout_en = 1'b0;
    case (mode)
      M_READ, M_VERIFY: begin
        dout    = rd_data;
        dout_en = 1'b1;
      end
      M_IDENT: begin
        dout    = DATA_W'(ident_pick(sel0, MFR_CODE, DEV_CODE));
        dout_en = 1'b1;
      end
      default: ;
    endcase
  end

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STANDBY) |-> (!dout_en && dout == '0));

  assert_outdis_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OUTDIS) |-> !dout_en);

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int STORE_AW = 10,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              mode_err
);

  otp_mode_e           mode;
  logic                wr_en;
  logic [STORE_AW-1:0] wr_addr;
  logic [DATA_W-1:0]   wr_data;
  logic [DATA_W-1:0]   rd_data;

  otp_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .id_hv(id_hv),
    .mode(mode), .mode_err(mode_err)
  );

  otp_prog_ctrl #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .din(din),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  otp_cell_array #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr[STORE_AW-1:0]), .rd_data(rd_data)
  );

  otp_out_mux #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel0(addr[0]), .rd_data(rd_data),
    .dout(dout), .dout_en(dout_en)
  );

  assert_error_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!dout_en && !wr_en));

  assert_illegal_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && vpp_hi) |-> mode_err);

  assert_inhibit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && oe_n && vpp_hi) |-> !dout_en);

endmodule

// File: tb/otp_byte_mem_test.sv
module otp_byte_mem_test;

  localparam int AW = 15;
  localparam int SAW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic ce_n = 1, oe_n = 1, vpp_hi = 0, id_hv = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, mode_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] ref_mem [int];
  bit ref_pulse = 0;

  always #2 clk = ~clk;

  otp_byte_mem uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .mode_err(mode_err)
  );

  function automatic logic [7:0] ref_get(int a);
    int k = a % (1 << SAW);
    return ref_mem.exists(k) ? ref_mem[k] : 8'hFF;
  endfunction

  // one clock: apply pins, compare at the falling edge, advance the model
  task automatic step(input bit c, input bit o, input bit v, input bit idf,
                      input int a, input logic [7:0] d, input string tag);
    logic [7:0] exp_d;
    bit exp_en, exp_err;
    ce_n = c; oe_n = o; vpp_hi = v; id_hv = idf; addr = AW'(a); din = d;
    exp_d = 8'h00; exp_en = 0; exp_err = 0;
    if (!c && !o && v) exp_err = 1;
    else if (!c && !o && idf) begin exp_en = 1; exp_d = a[0] ? 8'h8D : 8'h20; end
    else if (!c && !o) begin exp_en = 1; exp_d = ref_get(a); end
    else if (c && !o && v) begin exp_en = 1; exp_d = ref_get(a); end
    @(negedge clk);
    n_run++;
    if (dout !== exp_d || dout_en !== exp_en || mode_err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: dout=%h en=%b err=%b expected dout=%h en=%b err=%b",
               tag, dout, dout_en, mode_err, exp_d, exp_en, exp_err);
    end
    @(posedge clk);
    if (ref_pulse && c && v) ref_mem[a % (1 << SAW)] = ref_get(a) & d;
    ref_pulse = (!c && o && v);
    #1;
  endtask

  task automatic burn(input int a, input logic [7:0] d, input int len);
    for (int i = 0; i < len; i++) step(0, 1, 1, 0, a, d, "R6 pulse");
    step(1, 1, 1, 0, a, d, "R6 end");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 erased after reset
    step(0, 0, 0, 0, 0, 0, "R1 read 0");
    step(0, 0, 0, 0, 32767, 0, "R1 read top");
    // R2 R3 program and read
    burn(5, 8'hA5, 2);
    step(0, 0, 0, 0, 5, 0, "R3 read 5");
    burn(5, 8'h5A, 1);
    step(1, 0, 1, 0, 5, 0, "R8 verify 5");
    burn(7, 8'hF0, 3);
    burn(7, 8'hFF, 1);
    step(0, 0, 0, 0, 7, 0, "R2 no rise 7");
    // R4 standby, R5 output disable
    step(1, 0, 0, 0, 7, 0, "R4 standby oe low");
    step(1, 1, 0, 0, 7, 0, "R4 standby oe high");
    step(0, 1, 0, 0, 7, 0, "R5 output disable");
    // R7 inhibit holds off writes
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 9, 8'h00, "R7 inhibit");
    step(0, 0, 0, 0, 9, 0, "R7 read 9");
    // R9 identification
    step(0, 0, 0, 1, 512, 0, "R9 id lo");
    step(0, 0, 0, 1, 513, 0, "R9 id hi");
    // R10 illegal inside pulse
    step(0, 1, 1, 0, 12, 8'h00, "R10 pulse");
    step(0, 0, 1, 0, 12, 8'h00, "R10 illegal");
    step(1, 1, 1, 0, 12, 8'h00, "R10 after");
    step(0, 0, 0, 0, 12, 0, "R10 read 12");
    // R6 address and data at the rising edge
    step(0, 1, 1, 0, 10, 8'h00, "R6 pulse");
    step(1, 1, 1, 0, 11, 8'h3C, "R6 edge");
    step(0, 0, 0, 0, 10, 0, "R6 read 10");
    step(0, 0, 0, 0, 11, 0, "R6 read 11");
    // R6 supply dropped at the edge
    step(0, 1, 1, 0, 14, 8'h00, "R6 pulse");
    step(1, 1, 0, 0, 14, 8'h00, "R6 no vpp");
    step(0, 0, 0, 0, 14, 0, "R6 read 14");
    // R11 mirroring
    burn(2 + 1024, 8'h0F, 2);
    step(0, 0, 0, 0, 2, 0, "R11 alias 2");
    step(1, 0, 1, 0, 2 + 4096, 0, "R11 alias verify");
    // patterned sweep
    for (int a = 100; a < 116; a++) burn(a, 8'(a * 37), 1 + (a % 3));
    for (int a = 100; a < 116; a++) step(0, 0, 0, 0, a, 0, "R2 sweep");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule